// File: doc/BRIEF.md
# Serial J0 Trace Byte Driver

This block feeds the trace byte of a SONET transport overhead into a transmit framer through the framer's one-bit serial overhead input. The framer supplies the overhead clock together with an enable output and a frame-marker output. The driver runs entirely on that clock. It stays idle until it sees the enable and the frame marker high on the same rising edge. It then lets a fixed number of bit periods pass, which covers the two overhead bytes that come before the trace byte. After that it shifts out the eight bits of the byte, most significant bit first.

Each bit is launched on a falling edge of the overhead clock, so the framer samples it on the rising edge that follows. A host loads the byte value in parallel. The driver copies that value into a shadow register when a frame is detected, so the host can rewrite it at any time. An optional insert-request output frames the eight bit slots. A one-clock pulse signals that the byte has been sent. If a new frame marker arrives while a transfer is still running, the driver drops that transfer and starts again from the new frame.

Top module: `sohd_j0_driver`

## Requirements
- R1: While `rst` is high at a rising edge, and after it, `ser_data_o`, `ins_req_o` and `byte_done_o` are low, and the driver is idle until the next detection.
- R2: A transfer starts only when `oh_en_i` and `oh_frame_i` are both high at the same rising edge. Either one high alone has no effect on any output.
- R3: After the detection edge, `ser_data_o` and `ins_req_o` stay low for SKIP_BITS (default 16) clock periods.
- R4: Call the detection edge k. The most significant bit of the byte is launched on the falling edge after rising edge k+SKIP_BITS, so it is the value present at rising edge k+SKIP_BITS+1.
- R5: The BYTE_W bits go out one per clock, most significant first. Bit BYTE_W-1-i is present at rising edge k+SKIP_BITS+1+i.
- R6: `byte_done_o` is high for exactly one clock. It rises at the edge on which the last bit is sampled. On the falling edge that follows, `ser_data_o` returns low and the driver returns to idle.
- R7: The byte sent is the value of `j0_value_i` at the detection edge. Changes to `j0_value_i` during the wait or the shift do not alter the bits sent.
- R8: A new detection during the wait or the shift abandons the current transfer. The wait and the bit count restart from the new detection edge, with the byte value captured at that edge, and no done pulse is produced for the abandoned transfer.
- R9: With INS_EN=1, `ins_req_o` is high exactly during the BYTE_W bit slots. With INS_EN=0, `ins_req_o` is held low and `ser_data_o` behaves the same as with INS_EN=1.
- R10: After a completed transfer, the next detection starts a new, identical sequence, once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Overhead clock supplied by the framer |
| rst | input | 1 | Synchronous active-high reset |
| oh_en_i | input | 1 | Framer overhead enable output |
| oh_frame_i | input | 1 | Framer frame-marker output |
| j0_value_i | input | BYTE_W | Host-loaded trace byte value |
| ser_data_o | output | 1 | Serial overhead data to the framer, launched on falling edges |
| ins_req_o | output | 1 | Insert request, high during the bit slots (when INS_EN=1) |
| byte_done_o | output | 1 | One-clock pulse after the last bit |

## Verification
The bench builds two copies of the driver with the default SKIP_BITS=16 and BYTE_W=8, one with INS_EN=1 and one with INS_EN=0, and drives both from the same inputs. With the default skip length, the exact bit-slot timing relative to the detection edge can be checked on every cycle of the wait and the shift. Running the two insert-request variants side by side shows that the optional request line is gated correctly and never alters the data line. Restarts are forced both inside the wait and inside the shift, so the abandon-and-recount path is exercised in each phase.

// File: rtl/sohd_pkg.sv
package sohd_pkg;

    // Sequencer phase: idle, skipping leading overhead bits, shifting the byte
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_SHIFT = 2'd2
    } sohd_state_e;

    // Values launched together on a falling edge
    typedef struct packed {
        logic data;
        logic ins;
    } sohd_launch_t;

    // Counter width for a count of n, never below one bit
    function automatic int cnt_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sohd_seq.sv
module sohd_seq
    import sohd_pkg::*;
#(
    parameter int SKIP_BITS = 16,
    parameter int BYTE_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      det_i,
    output sohd_state_e               state_o,
    output logic [cnt_w(BYTE_W)-1:0]  bit_idx_o,
    output logic                      done_o
);
    localparam int SKW = cnt_w(SKIP_BITS);
    localparam int BW  = cnt_w(BYTE_W);
    localparam logic [SKW-1:0] SKIP_LAST = SKW'(SKIP_BITS - 1);
    localparam logic [BW-1:0]  BIT_LAST  = BW'(BYTE_W - 1);

    sohd_state_e      state_q;
    logic [SKW-1:0]   skip_q;
    logic [BW-1:0]    bit_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            skip_q  <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (det_i) begin
                // new frame always wins, abandoning any transfer in flight
                state_q <= ST_SKIP;
                skip_q  <= '0;
                bit_q   <= '0;
            end else begin
                case (state_q)
                    ST_SKIP: begin
                        if (skip_q == SKIP_LAST) begin
                            state_q <= ST_SHIFT;
                            bit_q   <= '0;
                        end else begin
                            skip_q <= skip_q + 1'b1;
                        end
                    end
                    ST_SHIFT: begin
                        if (bit_q == BIT_LAST) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign state_o   = state_q;
    assign bit_idx_o = bit_q;
    assign done_o    = done_q;

endmodule

// File: rtl/sohd_launch.sv
module sohd_launch
    import sohd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter bit INS_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_i,
    input  logic [BYTE_W-1:0]         value_i,
    input  sohd_state_e               state_i,
    input  logic [cnt_w(BYTE_W)-1:0]  bit_idx_i,
    output logic                      ser_o,
    output logic                      ins_o
);
    localparam int BW = cnt_w(BYTE_W);
    localparam logic [BW-1:0] MSB_IDX = BW'(BYTE_W - 1);

    logic [BYTE_W-1:0] shadow_q;
    sohd_launch_t      nxt;
    sohd_launch_t      out_q;

    // Shadow copy taken on the detection edge
    always_ff @(posedge clk) begin
        if (rst)         shadow_q <= '0;
        else if (load_i) shadow_q <= value_i;
    end

    always_comb begin
        nxt = '0;
        if (state_i == ST_SHIFT) begin
            nxt.data = shadow_q[MSB_IDX - bit_idx_i];
            nxt.ins  = 1'b1;
        end
    end

    // Launch on the falling edge so the framer samples on the next rising edge
    always_ff @(negedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt;
    end

    assign ser_o = out_q.data;

    generate
        if (INS_EN) begin : g_ins
            assign ins_o = out_q.ins;
        end else begin : g_no_ins
            assign ins_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sohd_j0_driver.sv
module sohd_j0_driver
    import sohd_pkg::*;
#(
    parameter int SKIP_BITS = 16,
    parameter int BYTE_W    = 8,
    parameter bit INS_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oh_en_i,
    input  logic              oh_frame_i,
    input  logic [BYTE_W-1:0] j0_value_i,
    output logic              ser_data_o,
    output logic              ins_req_o,
    output logic              byte_done_o
);
    localparam int BW = cnt_w(BYTE_W);

    logic              frame_det;
    sohd_state_e       seq_state;
    logic [BW-1:0]     seq_bit;

    assign frame_det = oh_en_i & oh_frame_i;

    sohd_seq #(
        .SKIP_BITS (SKIP_BITS),
        .BYTE_W    (BYTE_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .det_i     (frame_det),
        .state_o   (seq_state),
        .bit_idx_o (seq_bit),
        .done_o    (byte_done_o)
    );

    sohd_launch #(
        .BYTE_W (BYTE_W),
        .INS_EN (INS_EN)
    ) launch_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (frame_det),
        .value_i   (j0_value_i),
        .state_i   (seq_state),
        .bit_idx_i (seq_bit),
        .ser_o     (ser_data_o),
        .ins_o     (ins_req_o)
    );

endmodule

// File: rtl/sohd_j0_driver_chk.sv
module sohd_j0_driver_chk
    import sohd_pkg::*;
#(
    parameter bit INS_EN = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        oh_en_i,
    input logic        oh_frame_i,
    input logic        ser_data_o,
    input logic        ins_req_o,
    input logic        byte_done_o,
    input sohd_state_e state_q
);

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SKIP) |-> (!ser_data_o && !ins_req_o)); // R3

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        byte_done_o |=> !byte_done_o); // R6

    AST_DONE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
        byte_done_o |-> ($past(state_q) == ST_SHIFT)); // R6

    AST_RESTART_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (oh_en_i && oh_frame_i) |=> !byte_done_o); // R8

    AST_INS_GATES_DATA: assert property (@(posedge clk) disable iff (rst)
        (INS_EN && !ins_req_o) |-> !ser_data_o); // R9

    AST_SHIFT_HAS_INS: assert property (@(posedge clk) disable iff (rst)
        (INS_EN && state_q == ST_SHIFT) |-> ins_req_o); // R9

endmodule

bind sohd_j0_driver sohd_j0_driver_chk #(.INS_EN(INS_EN)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .oh_en_i     (oh_en_i),
    .oh_frame_i  (oh_frame_i),
    .ser_data_o  (ser_data_o),
    .ins_req_o   (ins_req_o),
    .byte_done_o (byte_done_o),
    .state_q     (seq_state)
);

// File: tb/sohd_j0_driver_tb_top.sv
`timescale 1ns/1ps
module sohd_j0_driver_tb_top;

    localparam int SKIP = 16;
    localparam int BW8  = 8;

    typedef struct packed {
        logic       en;
        logic       fr;
        logic [7:0] val;
        logic       xfer;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 8'hA5, 1'b1},
        '{1'b1, 1'b0, 8'h3C, 1'b0},
        '{1'b1, 1'b1, 8'h00, 1'b1},
        '{1'b0, 1'b1, 8'h3C, 1'b0},
        '{1'b1, 1'b1, 8'hFF, 1'b1},
        '{1'b0, 1'b0, 8'h77, 1'b0},
        '{1'b1, 1'b1, 8'h81, 1'b1},
        '{1'b1, 1'b1, 8'h6E, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       fr  = 1'b0;
    logic [7:0] j0  = 8'h00;
    logic       ser_a, ins_a, done_a;
    logic       ser_b, ins_b, done_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sohd_j0_driver #(.SKIP_BITS(SKIP), .BYTE_W(BW8), .INS_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .oh_en_i(en), .oh_frame_i(fr), .j0_value_i(j0),
        .ser_data_o(ser_a), .ins_req_o(ins_a), .byte_done_o(done_a));

    sohd_j0_driver #(.SKIP_BITS(SKIP), .BYTE_W(BW8), .INS_EN(1'b0)) dut_noins_i (
        .clk(clk), .rst(rst), .oh_en_i(en), .oh_frame_i(fr), .j0_value_i(j0),
        .ser_data_o(ser_b), .ins_req_o(ins_b), .byte_done_o(done_b));

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to 1.5 ns after the next rising edge
    task automatic tick();
        @(posedge clk);
        #1.5;
    endtask

    // Check both instances against expected data/ins/done
    task automatic expect_out(input logic d, input logic ins, input logic dn, input string req);
        chk(ser_a == d,   req, ser_a, d);
        chk(ins_a == ins, req, ins_a, ins);
        chk(done_a == dn, req, done_a, dn);
        chk(ser_b == d,   {req, " R9 noins data"}, ser_b, d);
        chk(ins_b == 1'b0, {req, " R9 noins ins"}, ins_b, 0);
        chk(done_b == dn, {req, " noins done"}, done_b, dn);
    endtask

    // Present en/frame for one edge; returns 1.5 ns after that edge (k)
    task automatic pulse(input logic e, input logic f, input logic [7:0] v);
        en = e; fr = f; j0 = v;
        tick();
        en = 1'b0; fr = 1'b0;
    endtask

    // From k+1.5: wait, bits, done, return to idle
    task automatic expect_byte(input logic [7:0] v, input string req);
        for (int w = 0; w < SKIP; w++) begin
            tick();
            expect_out(1'b0, 1'b0, 1'b0, {req, " R3 wait"});
        end
        for (int b = 0; b < BW8; b++) begin
            tick();
            expect_out(v[BW8-1-b], 1'b1, (b == BW8-1), {req, " R4 R5 bit"});
        end
        tick();
        expect_out(1'b0, 1'b0, 1'b0, {req, " R6 idle"});
    endtask

    task automatic expect_quiet(input int n, input string req);
        for (int w = 0; w < n; w++) begin
            tick();
            expect_out(1'b0, 1'b0, 1'b0, req);
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        // R1: reset state
        expect_out(1'b0, 1'b0, 1'b0, "R1 reset");
        rst = 1'b0;
        tick();
        expect_out(1'b0, 1'b0, 1'b0, "R1 after reset");

        // Vector table: R2 gating, R5 patterns, R10 repetition
        for (int i = 0; i < NVEC; i++) begin
            pulse(VECS[i].en, VECS[i].fr, VECS[i].val);
            if (VECS[i].xfer) expect_byte(VECS[i].val, "R10 vec");
            else              expect_quiet(SKIP + BW8 + 2, "R2 no start");
        end

        // R7: host write during the shift does not affect the byte
        pulse(1'b1, 1'b1, 8'hC3);
        for (int w = 0; w < SKIP; w++) tick();
        for (int b = 0; b < BW8; b++) begin
            tick();
            if (b == 2) j0 = 8'h00;
            expect_out(b < 8 ? 8'hC3 >> (BW8-1-b) & 1 : 0, 1'b1, (b == BW8-1), "R7 shadow");
        end
        tick();

        // R7: host write during the wait
        pulse(1'b1, 1'b1, 8'h96);
        j0 = 8'h5F;
        expect_byte(8'h96, "R7 wait write");

        // R8: restart during the wait
        pulse(1'b1, 1'b1, 8'h11);
        for (int w = 0; w < 10; w++) tick();
        pulse(1'b1, 1'b1, 8'hEE);
        expect_byte(8'hEE, "R8 restart wait");

        // R8: restart during the shift
        pulse(1'b1, 1'b1, 8'h0F);
        for (int w = 0; w < SKIP + 3; w++) tick();
        pulse(1'b1, 1'b1, 8'h5A);
        expect_byte(8'h5A, "R8 restart shift");

        // R1: reset in the middle of a shift
        pulse(1'b1, 1'b1, 8'hFF);
        for (int w = 0; w < SKIP + 4; w++) tick();
        rst = 1'b1;
        tick(); tick();
        expect_out(1'b0, 1'b0, 1'b0, "R1 mid reset");
        rst = 1'b0;
        expect_quiet(SKIP + BW8 + 2, "R1 stays idle");

        // R10: back-to-back frames after reset
        pulse(1'b1, 1'b1, 8'h24);
        expect_byte(8'h24, "R10 frame a");
        pulse(1'b1, 1'b1, 8'hDB);
        expect_byte(8'hDB, "R10 frame b");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule